// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block executes the commands that software issues to a standard hot-plug controller. That controller can manage up to 31 slots. The block decodes one command code byte and one target byte. There are four operation types: an operation on a single slot, a secondary bus speed request, "power-only every slot", and "enable every slot". The block checks each command against the current slot state. It then updates each slot's state field and its power and attention indicator fields, and reports the result in a 4-bit command status word. Every executed command also sets a command-detected flag, which the interrupt logic consumes.

Each slot holds the following:
- a status word with its state, power LED, attention LED, retention-latch (MRL) open flag and presence code;
- three sticky event bits that record a modelled device removal.

While reset is held, the status of each slot is loaded from the `init_present` strap for that slot. An occupied slot comes up enabled, latched and powered. An empty slot comes up disabled, unlatched and dark. The block does not sequence real slot power, switch the bus clock or enumerate devices.

Top module: `hp_cmd_engine`

## Requirements
- R1: While reset is held, each slot loads its status from `init_present`:
  - An occupied slot loads state 2, power LED 1, attention LED 0, MRL-open 0 and presence 2'b00 (status word 9'h006).
  - An empty slot loads state 3, power LED 3, attention LED 0, MRL-open 1 and presence 2'b11 (status word 9'h1CF).
  - All event bits, all command status bits and the command-detected flag reset to 0.
- R2: The code byte selects the operation:
  - 0x00–0x3F is a single-slot operation.
  - 0x40–0x47 is a set bus speed request.
  - 0x48 is power-only every slot.
  - 0x49 is enable every slot.
  - Any other code sets invalid-command (status bit 2).
- R3: In a single-slot code, bits [1:0] are the requested state, bits [3:2] are the power LED and bits [5:4] are the attention LED.
  - State encoding: 0 no change, 1 power only, 2 enabled, 3 disabled.
  - LED encoding: 0 no change, 1 on, 2 blink, 3 off.
  - A non-zero LED field overwrites that LED in the slot status word. The status word layout is [1:0] state, [3:2] power LED, [5:4] attention LED, [6] MRL-open, [8:7] presence.
- R4: The target is `cmd_target[4:0]`, and the slot index is the target minus 1. Bits [7:5] of the target byte are ignored. A target of 0, or a target above NSLOTS, sets invalid-command and changes no slot.
- R5: A power-only request to a slot that is currently enabled sets invalid-command and changes nothing in that slot, including its LEDs.
- R6: The state field changes only in these cases:
  - from disabled to power only;
  - from disabled to enabled;
  - from power only or enabled to disabled.
  Any other request keeps the old state and reports no error.
- R7: When a slot moves to disabled while its power LED (after this command's LED update) reads off, the slot is emptied:
  - MRL-open becomes 1 and presence becomes 2'b11.
  - The event bits presence [0], button [1] and MRL [2] are set. They stay set until reset.
- R8: Every command first clears busy (bit 0), MRL-open (bit 1), invalid-command (bit 2) and invalid-mode (bit 3) in `cmd_status`. The status word then shows only the errors of that command.
- R9: A bus speed request uses code bits [2:0]. The value 0 is accepted without error. Any other value sets invalid-mode (bit 3) and does not set invalid-command.
- R10: The two broadcast commands fail with invalid-command, and change nothing, if any slot is enabled. Otherwise:
  - Each slot with MRL closed receives the broadcast operation with the power LED on.
  - Each slot with MRL open receives "no state change, power LED off".
- R11: Every command sets `cmd_detected`. A `cmd_det_clr` pulse clears it, but a command in the same cycle takes priority over the clear.
- R12: A command is taken on the rising clock edge at which `cmd_wr` is high. All its effects on status, slot fields, events and `cmd_detected` are visible right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_present | input | NSLOTS | Per-slot occupied strap, sampled while reset is held |
| cmd_wr | input | 1 | High for one cycle when software writes the code or target byte |
| cmd_code | input | 8 | Command code byte |
| cmd_target | input | 8 | Command target byte |
| cmd_det_clr | input | 1 | Clears the command-detected flag |
| cmd_status | output | 4 | {invalid-mode, invalid-command, MRL-open, busy} |
| cmd_detected | output | 1 | Set by every executed command |
| slot_status | output | 9*NSLOTS | Per-slot status words, slot 0 in the low bits |
| slot_events | output | 3*NSLOTS | Per-slot {MRL, button, presence} event bits |

## Verification
Every result of a command is due exactly one clock edge after the cycle in which `cmd_wr` is high. The bench drives each command on a falling edge and holds it for one cycle. It reads status, slot fields, events and the detected flag at the next falling edge, which follows the single register stage. One directed test also reads the outputs between the drive and the capturing edge, to show that nothing changes early. The clear of the detected flag is checked in the same way, one edge after its pulse.

// File: rtl/hp_cmd_pkg.sv
// Package: shared encodings and the per-slot status layout for the hot-plug
// command engine. It assumes that every field decoded by software sits at
// the bit position given here.
package hp_cmd_pkg;

    localparam int STS_W = 9;
    localparam int EVT_W = 3;

    // Requested and current slot states.
    localparam logic [1:0] ST_NOCHG    = 2'd0;
    localparam logic [1:0] ST_PWRONLY  = 2'd1;
    localparam logic [1:0] ST_ENABLED  = 2'd2;
    localparam logic [1:0] ST_DISABLED = 2'd3;

    // Indicator encodings.
    localparam logic [1:0] LED_NOCHG = 2'd0;
    localparam logic [1:0] LED_ON    = 2'd1;
    localparam logic [1:0] LED_OFF   = 2'd3;

    localparam logic [1:0] PRES_EMPTY = 2'b11;
    localparam logic [1:0] PRES_LOW   = 2'b00;

    // Event bit positions.
    localparam int EVT_PRES = 0;
    localparam int EVT_BTN  = 1;
    localparam int EVT_MRL  = 2;

    typedef struct packed {
        logic [1:0] pres;
        logic       mrl_open;
        logic [1:0] attn;
        logic [1:0] pwr;
        logic [1:0] state;
    } slot_sts_t;

    typedef enum logic [2:0] {
        OP_SLOT,
        OP_SPEED,
        OP_PWR_ALL,
        OP_EN_ALL,
        OP_BAD
    } cmd_op_e;

endpackage

// File: rtl/hp_cmd_decode.sv
// Module: combinational decoder for the command code byte. It splits the
// code into an operation type and the three request fields of a single-slot
// command. It assumes that the caller qualifies the result with the write
// strobe.
module hp_cmd_decode
    import hp_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_op_e    op,
    output logic [1:0] req_state,
    output logic [1:0] req_pwr,
    output logic [1:0] req_attn,
    output logic [2:0] speed
);

    // Classify the code into one of the five operation types.
    always_comb begin
        if (code[7:6] == 2'b00)         op = OP_SLOT;
        else if (code[7:3] == 5'b01000) op = OP_SPEED;
        else if (code == 8'h48)         op = OP_PWR_ALL;
        else if (code == 8'h49)         op = OP_EN_ALL;
        else                            op = OP_BAD;
    end

    // Extract the fields of a single-slot command and the speed value.
    always_comb begin
        req_state = code[1:0];
        req_pwr   = code[3:2];
        req_attn  = code[5:4];
        speed     = code[2:0];
    end

endmodule

// File: rtl/hp_slot_reg.sv
// Module: status and event registers of one slot, with the legal-transition
// rules. The parent raises 'apply' only for a request it has already
// validated: the target is in range, and it is not power-only on an enabled
// slot.
module hp_slot_reg
    import hp_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_present,
    input  logic       apply,
    input  logic [1:0] req_state,
    input  logic [1:0] req_pwr,
    input  logic [1:0] req_attn,
    output slot_sts_t  sts,
    output logic [EVT_W-1:0] evt
);

    slot_sts_t        sts_nx;
    logic [EVT_W-1:0] evt_nx;
    logic             go_on;
    logic             go_off;

    // Compute the next status: LED overwrite, transition table, removal.
    always_comb begin
        sts_nx = sts;
        evt_nx = evt;
        go_on  = (sts.state == ST_DISABLED) &&
                 (req_state == ST_PWRONLY || req_state == ST_ENABLED);
        go_off = (sts.state == ST_ENABLED || sts.state == ST_PWRONLY) &&
                 (req_state == ST_DISABLED);
        if (apply) begin
            if (req_pwr != LED_NOCHG)  sts_nx.pwr  = req_pwr;
            if (req_attn != LED_NOCHG) sts_nx.attn = req_attn;
            if (go_on || go_off)       sts_nx.state = req_state;
            if (go_off && sts_nx.pwr == LED_OFF) begin
                sts_nx.mrl_open = 1'b1;
                sts_nx.pres     = PRES_EMPTY;
                evt_nx[EVT_PRES] = 1'b1;
                evt_nx[EVT_BTN]  = 1'b1;
                evt_nx[EVT_MRL]  = 1'b1;
            end
        end
    end

    // Register the slot, loading the occupancy strap while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts.state    <= init_present ? ST_ENABLED : ST_DISABLED;
            sts.pwr      <= init_present ? LED_ON : LED_OFF;
            sts.attn     <= LED_NOCHG;
            sts.mrl_open <= !init_present;
            sts.pres     <= init_present ? PRES_LOW : PRES_EMPTY;
            evt          <= '0;
        end else begin
            sts <= sts_nx;
            evt <= evt_nx;
        end
    end

    // R6: an enabled slot never drops straight to power-only.
    assert_no_enabled_to_pwronly_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(sts.state) == ST_ENABLED) |-> (sts.state != ST_PWRONLY));

    // R7: a disable with the power LED off leaves an emptied slot behind.
    assert_empty_on_removal_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(apply) && ($past(sts.state) == ST_ENABLED ||
                          $past(sts.state) == ST_PWRONLY) &&
         sts.state == ST_DISABLED && sts.pwr == LED_OFF)
        |-> (sts.mrl_open && sts.pres == PRES_EMPTY && evt == 3'b111));

endmodule

// File: rtl/hp_cmd_engine.sv
// Module: hot-plug command engine top level. It validates each command,
// steers per-slot requests into the slot registers and reports the outcome.
// It assumes that cmd_wr is high for exactly the cycle of a software write to
// the code or target byte, and that NSLOTS is between 1 and 31.
module hp_cmd_engine
    import hp_cmd_pkg::*;
#(
    parameter int NSLOTS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLOTS-1:0]       init_present,
    input  logic                    cmd_wr,
    input  logic [7:0]              cmd_code,
    input  logic [7:0]              cmd_target,
    input  logic                    cmd_det_clr,
    output logic [3:0]              cmd_status,
    output logic                    cmd_detected,
    output logic [NSLOTS*STS_W-1:0] slot_status,
    output logic [NSLOTS*EVT_W-1:0] slot_events
);

    localparam int TGT_W = 5;

    cmd_op_e          op;
    logic [1:0]       dec_state, dec_pwr, dec_attn;
    logic [2:0]       dec_speed;
    logic [TGT_W-1:0] tgt;
    logic             unused_tgt_hi;
    logic             tgt_ok;
    logic [1:0]       tgt_state;
    logic             any_en;
    logic             inv_cmd, inv_mode;
    logic [NSLOTS-1:0] apply;
    logic [1:0]       rq_st [NSLOTS];
    logic [1:0]       rq_pw [NSLOTS];
    logic [1:0]       rq_at [NSLOTS];
    slot_sts_t        sts   [NSLOTS];
    logic [2*NSLOTS-1:0] st_vec;

    hp_cmd_decode u_dec (
        .code      (cmd_code),
        .op        (op),
        .req_state (dec_state),
        .req_pwr   (dec_pwr),
        .req_attn  (dec_attn),
        .speed     (dec_speed)
    );

    assign tgt           = cmd_target[TGT_W-1:0];
    assign unused_tgt_hi = ^cmd_target[7:TGT_W];
    assign tgt_ok        = (tgt != '0) && (int'(tgt) <= NSLOTS);

    // Look up the addressed slot's state and check whether any slot is enabled.
    always_comb begin
        tgt_state = ST_NOCHG;
        any_en    = 1'b0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (int'(tgt) == i + 1) tgt_state = sts[i].state;
            if (sts[i].state == ST_ENABLED) any_en = 1'b1;
        end
    end

    // Validate the command and build the per-slot requests.
    always_comb begin
        apply    = '0;
        inv_cmd  = 1'b0;
        inv_mode = 1'b0;
        for (int i = 0; i < NSLOTS; i++) begin
            rq_st[i] = dec_state;
            rq_pw[i] = dec_pwr;
            rq_at[i] = dec_attn;
        end
        if (cmd_wr) begin
            case (op)
                OP_SLOT: begin
                    if (!tgt_ok) inv_cmd = 1'b1;
                    else if (tgt_state == ST_ENABLED && dec_state == ST_PWRONLY)
                        inv_cmd = 1'b1;
                    else
                        for (int i = 0; i < NSLOTS; i++)
                            if (int'(tgt) == i + 1) apply[i] = 1'b1;
                end
                OP_SPEED: begin
                    if (dec_speed != 3'd0) inv_mode = 1'b1;
                end
                OP_PWR_ALL, OP_EN_ALL: begin
                    if (any_en) inv_cmd = 1'b1;
                    else begin
                        for (int i = 0; i < NSLOTS; i++) begin
                            apply[i] = 1'b1;
                            rq_at[i] = LED_NOCHG;
                            if (!sts[i].mrl_open) begin
                                rq_st[i] = (op == OP_PWR_ALL) ? ST_PWRONLY : ST_ENABLED;
                                rq_pw[i] = LED_ON;
                            end else begin
                                rq_st[i] = ST_NOCHG;
                                rq_pw[i] = LED_OFF;
                            end
                        end
                    end
                end
                default: inv_cmd = 1'b1;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
            hp_slot_reg u_slot (
                .clk          (clk),
                .rst_n        (rst_n),
                .init_present (init_present[g]),
                .apply        (apply[g]),
                .req_state    (rq_st[g]),
                .req_pwr      (rq_pw[g]),
                .req_attn     (rq_at[g]),
                .sts          (sts[g]),
                .evt          (slot_events[g*EVT_W +: EVT_W])
            );
            assign slot_status[g*STS_W +: STS_W] = sts[g];
            assign st_vec[2*g +: 2]              = sts[g].state;
        end
    endgenerate

    // Replace the status word and set the detected flag on each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_status   <= '0;
            cmd_detected <= 1'b0;
        end else if (cmd_wr) begin
            cmd_status   <= {inv_mode, inv_cmd, 1'b0, 1'b0};
            cmd_detected <= 1'b1;
        end else if (cmd_det_clr) begin
            cmd_detected <= 1'b0;
        end
    end

    // R11: a command always leaves the detected flag set.
    assert_detect_after_cmd_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_detected);

    // R12: slot states move only in the cycle after a command.
    assert_state_moves_on_cmd_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_vec != $past(st_vec)) |-> $past(cmd_wr));

    // R5: a rejected command leaves every slot state untouched.
    assert_invalid_keeps_state_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(cmd_wr) && cmd_status[2]) |-> (st_vec == $past(st_vec)));

    // R9: a speed error never also flags an invalid command.
    assert_mode_excl_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        cmd_status[3] |-> !cmd_status[2]);

endmodule

// File: tb/hp_cmd_engine_test.sv
module hp_cmd_engine_test;

    localparam int NS = 4;
    localparam int NV = 21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] init_present;
    logic          cmd_wr, cmd_det_clr;
    logic [7:0]    cmd_code, cmd_target;
    logic [3:0]    cmd_status;
    logic          cmd_detected;
    logic [NS*9-1:0] slot_status;
    logic [NS*3-1:0] slot_events;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hp_cmd_engine #(.NSLOTS(NS)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_present (init_present),
        .cmd_wr       (cmd_wr),
        .cmd_code     (cmd_code),
        .cmd_target   (cmd_target),
        .cmd_det_clr  (cmd_det_clr),
        .cmd_status   (cmd_status),
        .cmd_detected (cmd_detected),
        .slot_status  (slot_status),
        .slot_events  (slot_events)
    );

    // {code, target, status, slot, slot status, slot events}; init slots 0..2 occupied
    localparam logic [33:0] VEC [NV] = '{
        {8'h01, 8'h01, 4'h4, 2'd0, 9'h006, 3'd0}, // R5 power-only on enabled
        {8'h00, 8'h00, 4'h4, 2'd0, 9'h006, 3'd0}, // R4 target zero
        {8'h00, 8'h05, 4'h4, 2'd3, 9'h1CF, 3'd0}, // R4 target above NSLOTS
        {8'h20, 8'h01, 4'h0, 2'd0, 9'h026, 3'd0}, // R3 attention blink
        {8'h03, 8'h01, 4'h0, 2'd0, 9'h027, 3'd0}, // R6 enabled->disabled, LED on
        {8'h0E, 8'h01, 4'h0, 2'd0, 9'h02E, 3'd0}, // R6 disabled->enabled, R3 LED off
        {8'h03, 8'h01, 4'h0, 2'd0, 9'h1EF, 3'd7}, // R7 removal
        {8'h45, 8'h00, 4'h8, 2'd0, 9'h1EF, 3'd7}, // R9 bad speed
        {8'h40, 8'h00, 4'h0, 2'd0, 9'h1EF, 3'd7}, // R9 speed 0, R8 clear
        {8'h80, 8'h00, 4'h4, 2'd1, 9'h006, 3'd0}, // R2 unknown code
        {8'h48, 8'h00, 4'h4, 2'd2, 9'h006, 3'd0}, // R10 blocked by enabled slot
        {8'h0F, 8'h03, 4'h0, 2'd2, 9'h1CF, 3'd7}, // R7 LED off and disable together
        {8'h07, 8'h02, 4'h0, 2'd1, 9'h007, 3'd0}, // R6 disable, LED on, MRL closed
        {8'h49, 8'h00, 4'h0, 2'd1, 9'h006, 3'd0}, // R10 enable every slot
        {8'h48, 8'h00, 4'h4, 2'd1, 9'h006, 3'd0}, // R10 blocked
        {8'h03, 8'h02, 4'h0, 2'd1, 9'h007, 3'd0}, // R6 disable
        {8'h48, 8'h00, 4'h0, 2'd1, 9'h005, 3'd0}, // R10 power-only every slot
        {8'h02, 8'h02, 4'h0, 2'd1, 9'h005, 3'd0}, // R6 power-only->enabled refused
        {8'h03, 8'h02, 4'h0, 2'd1, 9'h007, 3'd0}, // R6 power-only->disabled
        {8'h02, 8'h22, 4'h0, 2'd1, 9'h006, 3'd0}, // R4 high target bits ignored
        {8'h02, 8'h02, 4'h0, 2'd1, 9'h006, 3'd0}  // R6 enabled->enabled unchanged
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] code, input logic [7:0] tgt);
        @(negedge clk);
        cmd_code   = code;
        cmd_target = tgt;
        cmd_wr     = 1'b1;
        @(negedge clk);
        cmd_wr     = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; init_present = 4'b0111; cmd_wr = 1'b0; cmd_det_clr = 1'b0;
        cmd_code = 8'h00; cmd_target = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 status", 32'(cmd_status), 32'h0);
        chk("R1 detected", 32'(cmd_detected), 32'h0);
        chk("R1 slot0", 32'(slot_status[0 +: 9]), 32'h006);
        chk("R1 slot2", 32'(slot_status[18 +: 9]), 32'h006);
        chk("R1 slot3", 32'(slot_status[27 +: 9]), 32'h1CF);
        chk("R1 events", 32'(slot_events), 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [33:0] v;
            int s;
            v = VEC[k];
            s = int'(v[13:12]);
            issue(v[33:26], v[25:18]);
            chk($sformatf("vector %0d status R8", k), 32'(cmd_status), 32'(v[17:14]));
            chk($sformatf("vector %0d detected R11", k), 32'(cmd_detected), 32'h1);
            chk($sformatf("vector %0d slot %0d status R3", k, s),
                32'(slot_status[s*9 +: 9]), 32'(v[11:3]));
            chk($sformatf("vector %0d slot %0d events R7", k, s),
                32'(slot_events[s*3 +: 3]), 32'(v[2:0]));
        end
        chk("R10 open slot0 untouched", 32'(slot_status[0 +: 9]), 32'h1EF);

        // R12: nothing changes before the capturing edge
        @(negedge clk);
        cmd_code = 8'h80; cmd_target = 8'h00; cmd_wr = 1'b1;
        #1;
        chk("R12 status before edge", 32'(cmd_status), 32'h0);
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R12 status after edge", 32'(cmd_status), 32'h4);

        // R11: clear, then command wins over clear
        @(negedge clk);
        cmd_det_clr = 1'b1;
        @(negedge clk);
        cmd_det_clr = 1'b0;
        chk("R11 cleared", 32'(cmd_detected), 32'h0);
        @(negedge clk);
        chk("R11 stays clear", 32'(cmd_detected), 32'h0);
        cmd_code = 8'h40; cmd_wr = 1'b1; cmd_det_clr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_det_clr = 1'b0;
        chk("R11 cmd beats clear", 32'(cmd_detected), 32'h1);
        chk("R8 status after speed 0", 32'(cmd_status), 32'h0);

        // R1: reset again with another strap pattern
        init_present = 4'b1000; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset slot0", 32'(slot_status[0 +: 9]), 32'h1CF);
        chk("R1 re-reset slot3", 32'(slot_status[27 +: 9]), 32'h006);
        chk("R1 re-reset events", 32'(slot_events), 32'h0);
        chk("R1 re-reset detected", 32'(cmd_detected), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule